// File: doc/BRIEF.md
# Keyed-Arm Watchdog Timer

This peripheral supervises system software. A 32-bit up-counter advances on a slow functional tick of about 32 kHz, which reaches the block as a clock-enable (`tick_en`) in the fast bus clock domain. An optional prescaler can slow the counter further. When the counter wraps past all ones, the block raises a one-cycle reset request and restarts counting from the load register. Software can arm or disarm the counter only by writing two fixed key words, in order, to the key register. It refreshes the counter by writing a changed value to the kick register, which copies the load value into the counter. For a period of N seconds at 32768 ticks per second, software programs the load value 2^32 − N·32768.

The register bus is plain: an address, a write strobe with write data, and combinational read data. There is no valid/ready handshake and no back-pressure, so every write is accepted in the cycle it is presented. Writes to the control, counter, load, kick and key registers are posted. Each write lands in a staging slot, sets that register's busy flag, and takes effect on the `POST_TICKS`-th tick after the write. A second write to a busy register replaces the staged data and starts the wait again. Reads return the live, committed values.

Register offsets: identity 0x00, control 0x24, counter 0x28, load 0x2C, kick 0x30, busy status 0x34, key 0x48.

Top module: `kwd_top`

## Requirements
- R1: After reset the counter reads 0, the busy status reads 0, the counter is disarmed and `rst_req` is low.
- R2: The identity register reads the minor revision in bits 3:0, the major revision in bits 7:4, and zero above them.
- R3: A write to a posted register sets its busy bit in the next cycle. The bits are control 0, counter 1, load 2, kick 3 and key 4. The bit stays set, and the live value stays unchanged, until the `POST_TICKS`-th tick after the write commits it.
- R4: Committing 0x0000BBBB and then 0x00004444 as consecutive key words arms the counter. With the prescaler off, an armed counter advances by one on every tick, starting with the first tick after the arming commit.
- R5: Committing 0x0000AAAA and then 0x00005555 as consecutive key words disarms the counter. A disarmed counter holds its value across ticks.
- R6: Any other committed key word between the two halves of a sequence cancels it, so a later lone second half has no effect.
- R7: When control bit 5 is set, the counter advances once every 2^P ticks, where P is control bits 4:2. When bit 5 is clear, it advances on every tick.
- R8: Committing a kick value that differs from the current kick value copies the load register into the counter. Committing the same value changes nothing.
- R9: When an armed counter at 0xFFFFFFFF advances, `rst_req` is high for exactly one cycle and the counter takes the load value.
- R10: If a kick reload or a counter write commits on the same tick as a wrap, the software value wins and no reset request is raised.
- R11: Writes to the identity register, the busy status register or unmapped offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable per functional tick |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
A refresh and a timeout can fall on the same tick. The kick write is posted so that it commits on exactly the tick where the counter sits at 0xFFFFFFFF and would wrap. The bench places this by counting ticks from a known counter value. It then judges the outcome by two things: the reset-request pulse count stays unchanged, and the counter reads back the load value. The bench also checks that a counter write committing while the counter is running overrides the increment on that same tick.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int NUM_POST = 5;
  // busy-bit index of each posted register
  localparam int PI_CTRL = 0;
  localparam int PI_CNT  = 1;
  localparam int PI_LOAD = 2;
  localparam int PI_KICK = 3;
  localparam int PI_KEY  = 4;

  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h24;
  localparam logic [7:0] OFS_CNT  = 8'h28;
  localparam logic [7:0] OFS_LOAD = 8'h2C;
  localparam logic [7:0] OFS_KICK = 8'h30;
  localparam logic [7:0] OFS_BUSY = 8'h34;
  localparam logic [7:0] OFS_KEY  = 8'h48;

  localparam logic [31:0] KEY_ARM_A    = 32'h0000_BBBB;
  localparam logic [31:0] KEY_ARM_B    = 32'h0000_4444;
  localparam logic [31:0] KEY_DISARM_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_DISARM_B = 32'h0000_5555;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARM    = 2'd1,
    SEQ_DISARM = 2'd2
  } seq_state_t;
endpackage

// File: rtl/kwd_post.sv
module kwd_post #(
  parameter int DW         = 32,
  parameter int POST_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          fire,
  output logic [DW-1:0] data
);
  localparam int TW = $clog2(POST_TICKS + 1);

  logic [TW-1:0] left_q;

  // commit on the last tick of the wait, unless a fresh write restarts it
  assign fire = busy && tick_en && (left_q == TW'(1)) && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
      data   <= '0;
    end else if (wr_en) begin
      busy   <= 1'b1;
      left_q <= TW'(POST_TICKS);
      data   <= wr_data;
    end else if (busy && tick_en) begin
      left_q <= left_q - TW'(1);
      if (left_q == TW'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
  import kwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire,
  input  logic [31:0] word,
  output logic        run
);
  seq_state_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
      run  <= 1'b0;
    end else if (fire) begin
      if (st_q == SEQ_ARM && word == KEY_ARM_B) begin
        run  <= 1'b1;
        st_q <= SEQ_IDLE;
      end else if (st_q == SEQ_DISARM && word == KEY_DISARM_B) begin
        run  <= 1'b0;
        st_q <= SEQ_IDLE;
      end else if (word == KEY_ARM_A) begin
        st_q <= SEQ_ARM;
      end else if (word == KEY_DISARM_A) begin
        st_q <= SEQ_DISARM;
      end else begin
        st_q <= SEQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/kwd_core.sv
module kwd_core #(
  parameter int CNT_W = 32,
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_req
);
  localparam int PSC_W = (1 << PTV_W) - 1;

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_lim;
  logic             step;
  logic             wrap;

  assign psc_lim = ~({PSC_W{1'b1}} << ptv);
  assign step    = run && tick_en && (!pre_en || psc_q == psc_lim);
  assign wrap    = step && (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      psc_q <= '0;
    end else if (tick_en) begin
      psc_q <= step ? '0 : psc_q + PSC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      wrap_req <= 1'b0;
    end else begin
      wrap_req <= wrap && !reload && !cnt_wr;
      if (reload)      cnt <= load_val;
      else if (cnt_wr) cnt <= cnt_wdata;
      else if (wrap)   cnt <= load_val;
      else if (step)   cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int PTV_W      = 3,
  parameter int POST_TICKS = 2,
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam int PTV_LSB = 2;
  localparam int PRE_BIT = PTV_LSB + PTV_W;

  logic [ADDR_W-1:0] post_ofs [NUM_POST];
  assign post_ofs[PI_CTRL] = ADDR_W'(OFS_CTRL);
  assign post_ofs[PI_CNT]  = ADDR_W'(OFS_CNT);
  assign post_ofs[PI_LOAD] = ADDR_W'(OFS_LOAD);
  assign post_ofs[PI_KICK] = ADDR_W'(OFS_KICK);
  assign post_ofs[PI_KEY]  = ADDR_W'(OFS_KEY);

  logic [NUM_POST-1:0] busy_vec;
  logic [NUM_POST-1:0] fire_vec;
  logic [31:0]         pdata [NUM_POST];

  generate
    for (genvar i = 0; i < NUM_POST; i++) begin : g_post
      kwd_post #(.DW(32), .POST_TICKS(POST_TICKS)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (bus_we && bus_addr == post_ofs[i]),
        .wr_data (bus_wdata),
        .busy    (busy_vec[i]),
        .fire    (fire_vec[i]),
        .data    (pdata[i])
      );
    end
  endgenerate

  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] load_q;
  logic [31:0]      kick_q;
  logic [31:0]      key_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             reload;

  assign reload = fire_vec[PI_KICK] && (pdata[PI_KICK] != kick_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      kick_q <= '0;
      key_q  <= '0;
    end else begin
      if (fire_vec[PI_CTRL]) ctrl_q <= pdata[PI_CTRL];
      if (fire_vec[PI_LOAD]) load_q <= CNT_W'(pdata[PI_LOAD]);
      if (fire_vec[PI_KICK]) kick_q <= pdata[PI_KICK];
      if (fire_vec[PI_KEY])  key_q  <= pdata[PI_KEY];
    end
  end

  kwd_keyseq u_keyseq (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire_vec[PI_KEY]),
    .word  (pdata[PI_KEY]),
    .run   (run_q)
  );

  kwd_core #(.CNT_W(CNT_W), .PTV_W(PTV_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .run       (run_q),
    .pre_en    (ctrl_q[PRE_BIT]),
    .ptv       (ctrl_q[PTV_LSB +: PTV_W]),
    .cnt_wr    (fire_vec[PI_CNT]),
    .cnt_wdata (CNT_W'(pdata[PI_CNT])),
    .reload    (reload),
    .load_val  (load_q),
    .cnt       (cnt_q),
    .wrap_req  (rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_ID))
      bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
    else if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = ctrl_q;
    else if (bus_addr == ADDR_W'(OFS_CNT))  bus_rdata = 32'(cnt_q);
    else if (bus_addr == ADDR_W'(OFS_LOAD)) bus_rdata = 32'(load_q);
    else if (bus_addr == ADDR_W'(OFS_KICK)) bus_rdata = kick_q;
    else if (bus_addr == ADDR_W'(OFS_BUSY)) bus_rdata = 32'(busy_vec);
    else if (bus_addr == ADDR_W'(OFS_KEY))  bus_rdata = key_q;
  end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                rst_req,
  input logic                run,
  input logic [NUM_POST-1:0] status,
  input logic [CNT_W-1:0]    cnt
);
  // R3
  post_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_CTRL)) |=> status[PI_CTRL]);

  // R3
  busy_clears_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(status) & ~status)) |-> $past(tick_en));

  // R4
  cnt_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(tick_en));

  // R5
  run_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run) |-> $past(tick_en));

  // R9
  req_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(run) && $past(tick_en)));
endmodule

bind kwd_top kwd_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .rst_req  (rst_req),
  .run      (run_q),
  .status   (busy_vec),
  .cnt      (cnt_q)
);

// File: tb/kwd_top_bench.sv
module kwd_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int POST = 2;
  localparam logic [7:0] A_ID = 8'h00, A_CTRL = 8'h24, A_CNT = 8'h28,
    A_LOAD = 8'h2C, A_KICK = 8'h30, A_BUSY = 8'h34, A_KEY = 8'h48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  int pulse_cnt = 0;
  bit done = 0;

  typedef struct {
    bit          is_pulse;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  kwd_top u_kwd_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req)
  );

  always @(negedge clk) if (rst_n && rst_req === 1'b1) pulse_cnt++;

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_pulse ? 32'(pulse_cnt) : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic post(input logic [7:0] a, input logic [31:0] d);
    wr(a, d);
    tick(POST);
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_pulse = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_pulses(input int e, input string tag);
    item_t it;
    it.is_pulse = 1'b1; it.exp = 32'(e); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    chk(A_CNT, 32'h0, "R1 counter after reset");
    chk(A_BUSY, 32'h0, "R1 busy after reset");
    chk_pulses(0, "R1 no request after reset");
    chk(A_ID, 32'h21, "R2 identity");

    wr(A_LOAD, 32'h100);
    chk(A_BUSY, 32'h04, "R3 load busy set");
    chk(A_LOAD, 32'h0, "R3 load not yet live");
    tick(1);
    chk(A_BUSY, 32'h04, "R3 busy after one tick");
    tick(1);
    chk(A_BUSY, 32'h0, "R3 busy cleared");
    chk(A_LOAD, 32'h100, "R3 load committed");

    post(A_KICK, 32'h1);
    chk(A_CNT, 32'h100, "R8 kick reload");
    post(A_CNT, 32'h5);
    chk(A_CNT, 32'h5, "R8 counter written");
    post(A_KICK, 32'h1);
    chk(A_CNT, 32'h5, "R8 same kick ignored");

    wr(A_ID, 32'hFFFF_FFFF);
    wr(A_BUSY, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    chk(A_ID, 32'h21, "R11 identity unchanged");
    chk(A_BUSY, 32'h0, "R11 busy unchanged");

    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h1234);
    post(A_KEY, 32'h4444);
    tick(3);
    chk(A_CNT, 32'h5, "R6 broken sequence stays disarmed");

    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h4444);
    chk(A_CNT, 32'h5, "R4 no count on arming tick");
    tick(3);
    chk(A_CNT, 32'h8, "R4 one per tick");

    post(A_CTRL, 32'h28);
    chk(A_CNT, 32'hA, "R7 counts during control post");
    tick(3);
    chk(A_CNT, 32'hA, "R7 held for three ticks");
    tick(1);
    chk(A_CNT, 32'hB, "R7 advance on fourth tick");
    tick(4);
    chk(A_CNT, 32'hC, "R7 second period");
    post(A_CTRL, 32'h0);
    chk(A_CNT, 32'hC, "R7 prescaled during post");

    post(A_KEY, 32'hAAAA);
    post(A_KEY, 32'h5555);
    chk(A_CNT, 32'h10, "R5 count up to disarm");
    tick(3);
    chk(A_CNT, 32'h10, "R5 held while disarmed");

    post(A_CNT, 32'hFFFF_FFFE);
    post(A_LOAD, 32'h40);
    post(A_KEY, 32'hBBBB);
    post(A_KEY, 32'h4444);
    tick(1);
    chk(A_CNT, 32'hFFFF_FFFF, "R9 at top");
    chk_pulses(0, "R9 no request before wrap");
    tick(1);
    chk_pulses(1, "R9 request on wrap");
    chk(A_CNT, 32'h40, "R9 counter reloaded");
    tick(1);
    chk_pulses(1, "R9 request lasts one cycle");
    chk(A_CNT, 32'h41, "R9 counting resumes");

    post(A_CNT, 32'hFFFF_FFFD);
    chk(A_CNT, 32'hFFFF_FFFD, "R10 counter write beats increment");
    tick(1);
    wr(A_KICK, 32'h2);
    tick(2);
    chk_pulses(1, "R10 kick on wrap tick suppresses request");
    chk(A_CNT, 32'h40, "R10 counter takes load");

    cyc(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule